// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single FIFO-type cell of an inter-thread communication unit. Several hardware threads share it through one register-style request port. A 4-bit view code on each request chooses how the same storage is reached. A raw view peeks at the oldest entry or overwrites the newest one. A tag view exposes the cell's status word and lets software write its flags. Two queue views push on write and pop on read: one of them blocks and the other only tries. The cell holds a power-of-two circular buffer of data words, an output pointer, a fill count and three flags: empty, full and a general-purpose tag bit.

A blocking queue access that cannot go ahead does not wait inside the block. It returns at once with a stall response, and the block adds the requesting thread's ID to a blocked-thread bitmask. The next queue access that does go ahead, pushing or popping, sends the whole mask out as a one-cycle wake pulse and then clears it. The processor side uses that pulse to retry the parked threads. The request port always accepts (`req_ready` is tied high). Every accepted request gets exactly one response, one cycle later. The response has no back-pressure: the requester must take it in the cycle where `rsp_valid` is high.

Top module: `fifo_comm_cell`

## Requirements
- R1: After reset the count, pointer, data entries, tag bit, full flag and blocked mask are zero, and the empty flag is 1. A tag-view read then returns 64'h0000_0000_3002_0001 with the default depth of 8, and a raw read returns 0.
- R2: `req_ready` is always 1. A request with `req_valid` high produces `rsp_valid` high on the next cycle, and a cycle with no request produces no response. View codes are: 0 raw, 1 tag, 2 blocking queue, 3 non-blocking queue.
- R3: A tag-view read returns a word with the following fields: empty at bit 0, full at bit 1, tag bit at bit 16, a constant 1 at bit 17 (this cell is a queue), the fill count from bit 18 upward, and log2 of the depth in bits 31:28. All other bits are zero.
- R4: A tag-view write copies write-data bits 0, 1 and 16 into the empty, full and tag flags. When bit 0 is 1, the fill count is also set to zero. The pointer and the data are not changed.
- R5: A queue write first clears the empty flag. If it goes ahead and the count is below the depth, it stores the data at (pointer + count) mod depth and increments the count. If the count then equals the depth, the full flag is set. A non-blocking write to a full cell stores nothing.
- R6: A queue read first clears the full flag. If it goes ahead and the count is nonzero, it returns the entry at the pointer, advances the pointer mod depth and decrements the count. If the count is then zero, the empty flag is set. A non-blocking read of an empty cell returns 0 and does not stall.
- R7: A blocking read while the empty flag is set, or a blocking write while the full flag is set, returns `rsp_stall` = 1 and read data 0. It sets bit `req_tid` of the blocked mask and leaves the count, the pointer and the data unchanged. The only change is the flag clear described in R5/R6.
- R8: A queue access that does not stall, made while the blocked mask is nonzero, raises `wake_valid` for one cycle, aligned with its response, with `wake_mask` equal to the mask. The mask is then cleared. With no blocked threads, `wake_valid` stays 0.
- R9: A raw read returns the entry at the pointer and consumes nothing. A raw write replaces the entry at (pointer + count - 1) mod depth when the count is nonzero, and does nothing when the count is zero.
- R10: Any view code from 4 to 15 changes no state, does not stall, and returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1; every request is taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_view | input | 4 | View code selecting access semantics |
| req_tid | input | TIDW (6) | Hardware thread ID of requester |
| req_wdata | input | DW (64) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_stall | output | 1 | Blocking access could not proceed |
| rsp_rdata | output | DW (64) | Read data (0 for writes and stalls) |
| wake_valid | output | 1 | One-cycle pulse releasing blocked threads |
| wake_mask | output | 2**TIDW (64) | Threads to release, one bit per ID |

## Verification
The checker tests the following properties on every cycle:
- There is one response per request.
- The fill count never exceeds the depth.
- A stall leaves the count and the pointer where they were and records the requesting thread.
- A non-blocking access never stalls, and a blocking read of an empty cell always stalls.
- A wake pulse leaves the blocked mask empty.
- Unused view codes answer zero.

Data ordering, wrap-around of the circular buffer, the raw view's overwrite target, the effect of software-written flags, and the exact contents of the wake mask show up only in the bench's scenarios. The bench compares each response against a reference model of the cell.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [3:0] VW_RAW  = 4'd0;
  localparam logic [3:0] VW_TAG  = 4'd1;
  localparam logic [3:0] VW_WAIT = 4'd2;
  localparam logic [3:0] VW_POLL = 4'd3;

  localparam int TB_EMPTY = 0;
  localparam int TB_FULL  = 1;
  localparam int TB_TAG   = 16;
  localparam int TB_QUEUE = 17;
  localparam int TB_CNT   = 18;
  localparam int TB_DCODE = 28;
endpackage

// File: rtl/fcc_store.sv
module fcc_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) entry_q[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) entry_q[g] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/fcc_tag_ctrl.sv
module fcc_tag_ctrl
  import fcc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          is_wr,
  input  logic [3:0]    view,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] head_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] rd_val,
  output logic          stall,
  output logic          progress,
  output logic [AW-1:0] ptr_q,
  output logic [CW-1:0] cnt_q,
  output logic          e_q
);
  logic          f_q, t_q;
  logic          e_n, f_n, t_n;
  logic [AW-1:0] ptr_n;
  logic [CW-1:0] cnt_n;
  logic [DW-1:0] tag_word;
  logic          blocking;

  always_comb begin
    tag_word = '0;
    tag_word[TB_EMPTY] = e_q;
    tag_word[TB_FULL]  = f_q;
    tag_word[TB_TAG]   = t_q;
    tag_word[TB_QUEUE] = 1'b1;
    tag_word[TB_CNT +: CW]  = cnt_q;
    tag_word[TB_DCODE +: 4] = 4'(AW);
  end

  assign blocking = (view == VW_WAIT);

  always_comb begin
    e_n = e_q; f_n = f_q; t_n = t_q;
    cnt_n = cnt_q; ptr_n = ptr_q;
    wr_en = 1'b0; wr_addr = ptr_q;
    rd_val = '0; stall = 1'b0; progress = 1'b0;
    if (acc) begin
      unique case (view)
        VW_RAW: begin
          if (is_wr) begin
            if (cnt_q != '0) begin
              wr_en   = 1'b1;
              wr_addr = ptr_q + AW'(cnt_q - CW'(1));
            end
          end else begin
            rd_val = head_data;
          end
        end
        VW_TAG: begin
          if (is_wr) begin
            e_n = wdata[TB_EMPTY];
            f_n = wdata[TB_FULL];
            t_n = wdata[TB_TAG];
            if (wdata[TB_EMPTY]) cnt_n = '0;
          end else begin
            rd_val = tag_word;
          end
        end
        VW_WAIT, VW_POLL: begin
          if (!is_wr) begin
            f_n = 1'b0;
            if (blocking && e_q) begin
              stall = 1'b1;
            end else begin
              progress = 1'b1;
              if (cnt_q != '0) begin
                rd_val = head_data;
                ptr_n  = ptr_q + AW'(1);
                cnt_n  = cnt_q - CW'(1);
              end
              if (cnt_n == '0) e_n = 1'b1;
            end
          end else begin
            e_n = 1'b0;
            if (blocking && f_q) begin
              stall = 1'b1;
            end else begin
              progress = 1'b1;
              if (cnt_q < CW'(DEPTH)) begin
                wr_en   = 1'b1;
                wr_addr = ptr_q + AW'(cnt_q);
                cnt_n   = cnt_q + CW'(1);
              end
              if (cnt_n == CW'(DEPTH)) f_n = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q <= 1'b1; f_q <= 1'b0; t_q <= 1'b0;
      cnt_q <= '0; ptr_q <= '0;
    end else begin
      e_q <= e_n; f_q <= f_n; t_q <= t_n;
      cnt_q <= cnt_n; ptr_q <= ptr_n;
    end
  end
endmodule

// File: rtl/fcc_waitlist.sv
module fcc_waitlist #(
  parameter int TIDW = 6,
  localparam int NTHR = 1 << TIDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            park,
  input  logic [TIDW-1:0] tid,
  input  logic            release_all,
  output logic [NTHR-1:0] blocked_q,
  output logic            wake_valid,
  output logic [NTHR-1:0] wake_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked_q  <= '0;
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
      if (release_all && blocked_q != '0) begin
        wake_valid <= 1'b1;
        wake_mask  <= blocked_q;
        blocked_q  <= '0;
      end else if (park) begin
        blocked_q[tid] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fifo_comm_cell.sv
module fifo_comm_cell #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  parameter int TIDW  = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int NTHR = 1 << TIDW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [3:0]      req_view,
  input  logic [TIDW-1:0] req_tid,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic            rsp_stall,
  output logic [DW-1:0]   rsp_rdata,
  output logic            wake_valid,
  output logic [NTHR-1:0] wake_mask
);
  logic          wr_en, stall, progress, e_q;
  logic [AW-1:0] wr_addr, ptr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] head_data, rd_val;
  logic [NTHR-1:0] blocked_q;

  assign req_ready = 1'b1;

  fcc_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(req_wdata), .rd_addr(ptr_q), .rd_data(head_data)
  );

  fcc_tag_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc(req_valid), .is_wr(req_write),
    .view(req_view), .wdata(req_wdata), .head_data(head_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_val(rd_val), .stall(stall),
    .progress(progress), .ptr_q(ptr_q), .cnt_q(cnt_q), .e_q(e_q)
  );

  fcc_waitlist #(.TIDW(TIDW)) u_wait (
    .clk(clk), .rst_n(rst_n), .park(stall), .tid(req_tid),
    .release_all(progress), .blocked_q(blocked_q),
    .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_stall <= stall;
      rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  parameter int TIDW  = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int NTHR = 1 << TIDW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [3:0]      req_view,
  input logic [TIDW-1:0] req_tid,
  input logic            rsp_valid,
  input logic            rsp_stall,
  input logic [DW-1:0]   rsp_rdata,
  input logic            wake_valid,
  input logic [NTHR-1:0] wake_mask,
  input logic [CW-1:0]   cnt,
  input logic [AW-1:0]   ptr,
  input logic [NTHR-1:0] blocked,
  input logic            e_flag
);
  // R2
  always_comb ready_high_chk: assert (req_ready);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R7
  stall_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> (cnt == $past(cnt) && ptr == $past(ptr)));

  // R7
  stall_records_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_stall |-> blocked[$past(req_tid)]);

  // R7
  empty_wait_read_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view == 4'd2 && !req_write && e_flag) |=> rsp_stall);

  // R6
  poll_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view == 4'd3) |=> !rsp_stall);

  // R8
  wake_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (blocked == '0 && wake_mask != '0));

  // R10
  unused_view_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view > 4'd3) |=> (!rsp_stall && rsp_rdata == '0));
endmodule

bind fifo_comm_cell fcc_checker #(.DEPTH(DEPTH), .DW(DW), .TIDW(TIDW)) u_fcc_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_view(req_view), .req_tid(req_tid),
  .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
  .wake_valid(wake_valid), .wake_mask(wake_mask),
  .cnt(cnt_q), .ptr(ptr_q), .blocked(blocked_q), .e_flag(e_q)
);

// File: tb/test_fifo_comm_cell.sv
module test_fifo_comm_cell;
  localparam int DEPTH = 8;
  localparam int DW    = 64;
  localparam int TIDW  = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_view = '0;
  logic [TIDW-1:0] req_tid = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_stall, wake_valid;
  logic [DW-1:0] rsp_rdata;
  logic [63:0] wake_mask;

  fifo_comm_cell #(.DEPTH(DEPTH), .DW(DW), .TIDW(TIDW)) i_fifo_comm_cell (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_view(req_view), .req_tid(req_tid),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_stall(rsp_stall),
    .rsp_rdata(rsp_rdata), .wake_valid(wake_valid), .wake_mask(wake_mask)
  );

  int checks = 0, errors = 0;
  logic [63:0] m_mem [DEPTH];
  int m_ptr = 0, m_cnt = 0;
  bit m_e = 1, m_f = 0, m_t = 0;
  logic [63:0] m_blk = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_tag();
    return (64'(3) << 28) | (64'(m_cnt) << 18) | (64'(1) << 17) |
           (64'(m_t) << 16) | (64'(m_f) << 1) | 64'(m_e);
  endfunction

  task automatic access(bit wr, logic [3:0] view, int tid, logic [63:0] wd);
    logic [63:0] x_rd = '0;
    bit x_st = 0, x_wk = 0;
    logic [63:0] x_wm = '0;
    string lab;
    bit blk = (view == 4'd2);
    case (view)
      4'd0: begin
        lab = "R9";
        if (wr) begin
          if (m_cnt > 0) m_mem[(m_ptr + m_cnt - 1) % DEPTH] = wd;
        end else x_rd = m_mem[m_ptr];
      end
      4'd1: begin
        lab = "R3/R4";
        if (wr) begin
          m_e = wd[0]; m_f = wd[1]; m_t = wd[16];
          if (wd[0]) m_cnt = 0;
        end else x_rd = m_tag();
      end
      4'd2, 4'd3: begin
        if (!wr) begin
          lab = "R6";
          m_f = 0;
          if (blk && m_e) x_st = 1;
          else begin
            if (m_cnt > 0) begin
              x_rd = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % DEPTH; m_cnt--;
            end
            if (m_cnt == 0) m_e = 1;
          end
        end else begin
          lab = "R5";
          m_e = 0;
          if (blk && m_f) x_st = 1;
          else begin
            if (m_cnt < DEPTH) begin
              m_mem[(m_ptr + m_cnt) % DEPTH] = wd; m_cnt++;
            end
            if (m_cnt == DEPTH) m_f = 1;
          end
        end
        if (x_st) begin
          lab = "R7"; m_blk[tid] = 1'b1;
        end else if (m_blk != 0) begin
          x_wk = 1; x_wm = m_blk; m_blk = '0;
        end
      end
      default: lab = "R10";
    endcase
    @(negedge clk);
    req_valid = 1; req_write = wr; req_view = view;
    req_tid = TIDW'(tid); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({lab, " stall"}, 64'(rsp_stall), 64'(x_st));
    chk({lab, " rdata"}, rsp_rdata, x_rd);
    chk("R8 wake_valid", 64'(wake_valid), 64'(x_wk));
    chk("R8 wake_mask", wake_mask, x_wm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R2 no response when idle
    chk("R2 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 ready", 64'(req_ready), 64'd1);
    access(0, 4'd1, 0, '0);
    chk("R1 reset tag", m_tag(), 64'h0000_0000_3002_0001);
    access(0, 4'd0, 0, '0);
    // R6 try read of empty; R7 blocking read of empty parks threads 3 and 40
    access(0, 4'd3, 1, '0);
    access(0, 4'd2, 3, '0);
    access(0, 4'd2, 40, '0);
    // R9 raw write with count zero ignored
    access(1, 4'd0, 0, 64'hDEAD);
    access(0, 4'd0, 0, '0);
    // R5 fill to full, first push wakes threads (R8)
    for (int i = 0; i < DEPTH + 1; i++) access(1, 4'd3, 2, 64'h100 + 64'(i));
    access(0, 4'd1, 0, '0);
    access(1, 4'd2, 7, 64'h77);
    access(1, 4'd0, 0, 64'hABCD);
    access(0, 4'd0, 0, '0);
    // drain with wrap, wakes thread 7
    for (int i = 0; i < 3; i++) access(0, 4'd2, 4, '0);
    for (int i = 0; i < 5; i++) access(1, 4'd3, 5, 64'h200 + 64'(i));
    for (int i = 0; i < DEPTH + 1; i++) access(0, 4'd3, 6, '0);
    // R4 control writes: set T and F, then E clears count
    access(1, 4'd3, 1, 64'h55);
    access(1, 4'd1, 0, 64'h0001_0002);
    access(0, 4'd1, 0, '0);
    access(1, 4'd2, 9, 64'h66);
    access(1, 4'd1, 0, 64'h0000_0001);
    access(0, 4'd1, 0, '0);
    // R10 unused codes
    access(1, 4'd5, 0, 64'h1);
    access(0, 4'd15, 0, '0);
    access(0, 4'd1, 0, '0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom % 16);
      bit w = 1'($urandom % 2);
      int tid = int'($urandom % 64);
      logic [63:0] d = {$urandom, $urandom};
      logic [3:0] v;
      if (r < 2) v = 4'd0;
      else if (r < 3) v = 4'd1;
      else if (r < 9) v = 4'd2;
      else if (r < 15) v = 4'd3;
      else v = 4'(4 + $urandom % 12);
      if (v == 4'd1 && w) d = d & 64'h0001_0003;
      if (v == 4'd1 && w && ($urandom % 4 != 0)) d[0] = 1'b0;
      access(w, v, tid, d);
    end
    access(0, 4'd1, 0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule